// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Flow Control

This block is an 8-bit clock-synchronous serial port. A host writes a transmit buffer, reads a receive buffer and sets a handful of enable and mode inputs. Each frame carries exactly eight data bits, least significant first, with no framing bits. With clock polarity fixed so that idle is high, outgoing data changes on each falling edge of the transfer clock and incoming data is captured on each rising edge.

In master mode the port generates the transfer clock from a prescaler and a baud divider. In slave mode it follows an external clock brought through a two-flop synchroniser with edge detection; that clock must run slower than a quarter of the system clock. In both modes a frame starts only when the buffer holds data, transmit is enabled and the clear-to-send input is low. A frame that is already running always completes. Receiving therefore needs a loaded transmit frame, which may be dummy data. A ready-to-receive output goes high when a frame lands in the receive buffer and falls when the host reads it. Transmit and receive interrupt flags are held until acknowledged.

Top module: `sync_serial_port`

## Requirements
- R1: After reset ser_clk_out=1, ser_txd=1, stat_tbuf_empty=1, stat_tx_idle=1, stat_rx_full=0, host_rovr=0, host_rdata=0, rts=0, irq_tx=0 and irq_rx=0.
- R2: In master mode (cfg_ext_clk=0) each half period of ser_clk_out lasts (cfg_brg+1)*2^cfg_pre clock cycles, where cfg_pre=0 means undivided. The clock idles high and gives eight low pulses per frame.
- R3: Bits leave on ser_txd least significant bit first, changing only on a falling transfer-clock edge. ser_txd returns to 1 after the last bit. ser_rxd is shifted in LSB first on each rising edge.
- R4: A frame starts when the buffer is full, cfg_tx_en=1, cts_n=0 and no frame is running. At that point the buffer moves to the shifter, stat_tbuf_empty rises and irq_tx sets. A host_wr fills the buffer and clears stat_tbuf_empty.
- R5: While cts_n=1 or cfg_tx_en=0 no frame starts. A frame already running completes.
- R6: stat_tx_idle is 1 only when the buffer is empty and no frame is running.
- R7: When a frame completes with cfg_rx_en=1, host_rdata takes the received byte and stat_rx_full, irq_rx and rts go to 1.
- R8: A host_rd pulse clears stat_rx_full and host_rovr and drives rts low.
- R9: A frame that completes while stat_rx_full=1 and no read is under way sets host_rovr and replaces host_rdata.
- R10: In slave mode (cfg_ext_clk=1) the shifters follow the synchronised ser_clk_in edges, but only while a loaded frame runs. Without a host write, external clocking receives nothing.
- R11: ack_tx clears irq_tx and ack_rx clears irq_rx.
- R12: With cfg_rx_en=0 a completed frame leaves stat_rx_full, host_rdata and rts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext_clk | input | 1 | 1 selects slave mode (external clock) |
| cfg_brg | input | BRG_W | Baud divider value m |
| cfg_pre | input | PRE_W | Prescaler setting n (divide by 2^n) |
| host_wr | input | 1 | Write pulse for the transmit buffer |
| host_wdata | input | 8 | Transmit buffer data |
| host_rd | input | 1 | Read pulse for the receive buffer |
| host_rdata | output | 8 | Receive buffer contents |
| host_rovr | output | 1 | Overrun bit of the receive word |
| stat_tbuf_empty | output | 1 | Transmit buffer empty |
| stat_tx_idle | output | 1 | Buffer and shifter both empty |
| stat_rx_full | output | 1 | Receive buffer holds unread data |
| irq_tx | output | 1 | Transmit interrupt request flag |
| irq_rx | output | 1 | Receive interrupt request flag |
| ack_tx | input | 1 | Clears irq_tx |
| ack_rx | input | 1 | Clears irq_rx |
| ser_clk_in | input | 1 | External transfer clock (slave mode) |
| ser_clk_out | output | 1 | Generated transfer clock (master mode, idle high) |
| ser_rxd | input | 1 | Serial data in |
| ser_txd | output | 1 | Serial data out |
| cts_n | input | 1 | Clear to send, low allows a frame start |
| rts | output | 1 | High while the receive buffer is unread |

## Verification
The hardest case to reach is slave-mode reception, because it happens only after a dummy transmit write has armed the shifter while the external clock idles high. The bench first drives a full external byte with nothing written, to show that nothing is captured. It then writes a dummy byte, waits for the load and clocks a second byte in. At each falling phase it sets ser_rxd, and at the end of each low phase it samples ser_txd, so the two directions are checked against each other. The overrun case is reached in master mode by queuing a second write while the first frame shifts, so two frames complete back to back with no read in between.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int FRAME_BITS = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [FRAME_BITS-1:0] tbuf;
        logic                  tfull;
        logic [FRAME_BITS-1:0] tsh;
        logic [FRAME_BITS-1:0] rsh;
        logic [CNT_W-1:0]      bitcnt;
        logic                  busy;
        logic                  sclk;
        logic                  txd;
        logic [FRAME_BITS-1:0] rbuf;
        logic                  rfull;
        logic                  ovr;
        logic                  rts;
        logic                  tirq;
        logic                  rirq;
    } ssp_state_t;

    localparam ssp_state_t SSP_RST = '{sclk: 1'b1, txd: 1'b1, default: '0};
endpackage

// File: rtl/ssp_brg.sv
module ssp_brg #(
    parameter int BRG_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [BRG_W-1:0] brg,
    input  logic [PRE_W-1:0] pre,
    output logic             half_tick
);
    localparam int PRE_SPAN = (1 << PRE_W) - 1;

    typedef struct packed {
        logic [PRE_SPAN-1:0] pre_cnt;
        logic [BRG_W-1:0]    div;
    } brg_state_t;

    brg_state_t s_d, s_q;
    logic [PRE_SPAN-1:0] mask;
    logic                src_tick;

    always_comb begin
        mask      = (PRE_SPAN'(1) << pre) - PRE_SPAN'(1);
        src_tick  = ((s_q.pre_cnt & mask) == mask);
        half_tick = run && src_tick && (s_q.div == brg);
        s_d       = s_q;
        if (!run) begin
            s_d = '0;
        end else begin
            s_d.pre_cnt = s_q.pre_cnt + PRE_SPAN'(1);
            if (src_tick)
                s_d.div = (s_q.div == brg) ? '0 : s_q.div + BRG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the divider never passes the programmed value during a frame
    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.div <= brg));
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic rxd_in,
    output logic rise,
    output logic fall,
    output logic rxd_s
);
    typedef struct packed {
        logic [2:0] ck;
        logic [1:0] dt;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d.ck = {s_q.ck[1:0], sclk_in};
        s_d.dt = {s_q.dt[0], rxd_in};
        rise   = s_q.ck[1] && !s_q.ck[2];
        fall   = !s_q.ck[1] && s_q.ck[2];
        rxd_s  = s_q.dt[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ck: 3'b111, dt: 2'b11};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int BRG_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_tx_en,
    input  logic             cfg_rx_en,
    input  logic             cfg_ext_clk,
    input  logic [BRG_W-1:0] cfg_brg,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic             host_wr,
    input  logic [7:0]       host_wdata,
    input  logic             host_rd,
    output logic [7:0]       host_rdata,
    output logic             host_rovr,
    output logic             stat_tbuf_empty,
    output logic             stat_tx_idle,
    output logic             stat_rx_full,
    output logic             irq_tx,
    output logic             irq_rx,
    input  logic             ack_tx,
    input  logic             ack_rx,
    input  logic             ser_clk_in,
    output logic             ser_clk_out,
    input  logic             ser_rxd,
    output logic             ser_txd,
    input  logic             cts_n,
    output logic             rts
);
    ssp_state_t s_d, s_q;
    logic half_tick, ext_rise, ext_fall, rxd_sync;
    logic fall_ev, rise_ev, done_ev, commit, start, rxd_use;

    ssp_brg #(.BRG_W(BRG_W), .PRE_W(PRE_W)) u_brg (
        .clk(clk), .rst_n(rst_n), .run(s_q.busy && !cfg_ext_clk),
        .brg(cfg_brg), .pre(cfg_pre), .half_tick(half_tick));

    ssp_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(ser_clk_in), .rxd_in(ser_rxd),
        .rise(ext_rise), .fall(ext_fall), .rxd_s(rxd_sync));

    always_comb begin
        fall_ev = s_q.busy && (cfg_ext_clk ? ext_fall : (half_tick && s_q.sclk));
        rise_ev = s_q.busy && (cfg_ext_clk ? ext_rise : (half_tick && !s_q.sclk));
        rxd_use = cfg_ext_clk ? rxd_sync : ser_rxd;
        done_ev = rise_ev && (s_q.bitcnt == CNT_W'(FRAME_BITS - 1));
        commit  = done_ev && cfg_rx_en;
        start   = !s_q.busy && s_q.tfull && cfg_tx_en && !cts_n;

        s_d = s_q;
        if (ack_tx) s_d.tirq = 1'b0;
        if (ack_rx) s_d.rirq = 1'b0;

        if (start) begin
            s_d.busy   = 1'b1;
            s_d.tsh    = s_q.tbuf;
            s_d.tfull  = 1'b0;
            s_d.bitcnt = '0;
            s_d.tirq   = 1'b1;
        end
        if (fall_ev) begin
            if (!cfg_ext_clk) s_d.sclk = 1'b0;
            s_d.txd = s_q.tsh[0];
            s_d.tsh = s_q.tsh >> 1;
        end
        if (rise_ev) begin
            if (!cfg_ext_clk) s_d.sclk = 1'b1;
            s_d.rsh    = {rxd_use, s_q.rsh[FRAME_BITS-1:1]};
            s_d.bitcnt = s_q.bitcnt + CNT_W'(1);
            if (done_ev) begin
                s_d.busy   = 1'b0;
                s_d.txd    = 1'b1;
                s_d.bitcnt = '0;
            end
        end

        if (host_wr) begin
            s_d.tbuf  = host_wdata;
            s_d.tfull = 1'b1;
        end

        if (commit) begin
            s_d.rbuf  = {rxd_use, s_q.rsh[FRAME_BITS-1:1]};
            s_d.ovr   = s_q.rfull && !host_rd;
            s_d.rfull = 1'b1;
            s_d.rts   = 1'b1;
            s_d.rirq  = 1'b1;
        end else if (host_rd) begin
            s_d.rfull = 1'b0;
            s_d.ovr   = 1'b0;
            s_d.rts   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SSP_RST;
        else        s_q <= s_d;
    end

    assign host_rdata      = s_q.rbuf;
    assign host_rovr       = s_q.ovr;
    assign stat_tbuf_empty = !s_q.tfull;
    assign stat_tx_idle    = !s_q.tfull && !s_q.busy;
    assign stat_rx_full    = s_q.rfull;
    assign irq_tx          = s_q.tirq;
    assign irq_rx          = s_q.rirq;
    assign ser_clk_out     = s_q.sclk;
    assign ser_txd         = s_q.txd;
    assign rts             = s_q.rts;

    // R2: no transfer clock activity outside a frame
    p_clk_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> s_q.sclk);
    // R4: every frame start raises the transmit request
    p_start_sets_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> s_q.tirq);
    // R3: serial output moves only on a falling edge or at frame end
    p_txd_on_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_ev && !done_ev) |=> $stable(s_q.txd));
    // R7: a full receive buffer always holds rts high
    p_rts_with_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rfull |-> s_q.rts);
    // R8: a read without a coincident arrival empties the buffer
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !commit) |=> !stat_rx_full);
    // R9: overrun only appears on top of an unread buffer
    p_ovr_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovr) |-> $past(s_q.rfull));
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_tx_en = 0, cfg_rx_en = 0, cfg_ext_clk = 0;
    logic [7:0] cfg_brg = 0;
    logic [3:0] cfg_pre = 0;
    logic host_wr = 0, host_rd = 0, ack_tx = 0, ack_rx = 0;
    logic [7:0] host_wdata = 0;
    logic ser_clk_in = 1, ser_rxd = 1, cts_n = 0;
    logic [7:0] host_rdata;
    logic host_rovr, stat_tbuf_empty, stat_tx_idle, stat_rx_full;
    logic irq_tx, irq_rx, ser_clk_out, ser_txd, rts;

    always #5 clk = ~clk;

    sync_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_ext_clk(cfg_ext_clk), .cfg_brg(cfg_brg), .cfg_pre(cfg_pre),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rovr(host_rovr),
        .stat_tbuf_empty(stat_tbuf_empty), .stat_tx_idle(stat_tx_idle),
        .stat_rx_full(stat_rx_full), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .ack_tx(ack_tx), .ack_rx(ack_rx), .ser_clk_in(ser_clk_in),
        .ser_clk_out(ser_clk_out), .ser_rxd(ser_rxd), .ser_txd(ser_txd),
        .cts_n(cts_n), .rts(rts));

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // peer device for master mode: shifts its word out on each falling clock
    logic [15:0] peer_sh = 0;
    always @(negedge ser_clk_out) begin
        if (!cfg_ext_clk) begin
            ser_rxd = peer_sh[0];
            peer_sh = peer_sh >> 1;
        end
    end

    // behavioural reference model, cycle by cycle
    bit   model_on = 0;
    logic [7:0] m_tbuf, m_tsh, m_rsh, m_rbuf;
    logic m_tfull, m_busy, m_sclk, m_txd, m_rfull, m_ovr, m_rts, m_tirq, m_rirq;
    int   m_t, m_k, m_j;
    bit   m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tbuf = 0; m_tsh = 0; m_rsh = 0; m_rbuf = 0;
            m_tfull = 0; m_busy = 0; m_sclk = 1; m_txd = 1;
            m_rfull = 0; m_ovr = 0; m_rts = 0; m_tirq = 0; m_rirq = 0;
            m_t = 0; m_k = 1;
        end else begin
            m_done = 0;
            if (ack_tx) m_tirq = 0;
            if (ack_rx) m_rirq = 0;
            if (m_busy) begin
                m_t++;
                if (m_t % m_k == 0) begin
                    m_j = m_t / m_k;
                    if (m_j % 2 == 1) begin
                        m_sclk = 0; m_txd = m_tsh[0]; m_tsh = m_tsh >> 1;
                    end else begin
                        m_sclk = 1; m_rsh = {ser_rxd, m_rsh[7:1]};
                        if (m_j == 16) begin m_busy = 0; m_txd = 1; m_done = 1; end
                    end
                end
            end else if (m_tfull && cfg_tx_en && !cts_n) begin
                m_busy = 1; m_t = 0; m_tsh = m_tbuf; m_tfull = 0; m_tirq = 1;
                m_k = (int'(cfg_brg) + 1) << cfg_pre;
            end
            if (host_wr) begin m_tbuf = host_wdata; m_tfull = 1; end
            if (m_done && cfg_rx_en) begin
                m_ovr = m_rfull && !host_rd; m_rbuf = m_rsh;
                m_rfull = 1; m_rts = 1; m_rirq = 1;
            end else if (host_rd) begin
                m_rfull = 0; m_ovr = 0; m_rts = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R2 clk",        ser_clk_out,     m_sclk);
            check("R3 txd",        ser_txd,         m_txd);
            check("R4 tbuf_empty", stat_tbuf_empty, !m_tfull);
            check("R6 tx_idle",    stat_tx_idle,    !m_tfull && !m_busy);
            check("R7 rx_full",    stat_rx_full,    m_rfull);
            check("R7 rdata",      host_rdata,      m_rbuf);
            check("R9 rovr",       host_rovr,       m_ovr);
            check("R8 rts",        rts,             m_rts);
            check("R11 irq_tx",    irq_tx,          m_tirq);
            check("R11 irq_rx",    irq_rx,          m_rirq);
        end
    end

    task automatic pulse_wr(input logic [7:0] d);
        host_wdata = d; host_wr = 1; @(negedge clk); host_wr = 0;
    endtask
    task automatic pulse_rd();
        host_rd = 1; @(negedge clk); host_rd = 0;
    endtask
    task automatic wait_done();
        repeat (2) @(negedge clk);
        while (!stat_tx_idle) @(negedge clk);
        @(negedge clk);
    endtask
    task automatic ext_frame(input logic [7:0] rxb, output logic [7:0] txcap);
        for (int b = 0; b < 8; b++) begin
            ser_clk_in = 0; ser_rxd = rxb[b];
            repeat (8) @(negedge clk);
            txcap[b] = ser_txd;
            ser_clk_in = 1;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] cap;
        repeat (3) @(negedge clk);
        rst_n = 1; model_on = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 clk",  ser_clk_out, 1);
        check("R1 txd",  ser_txd, 1);
        check("R1 flags", {stat_tbuf_empty, stat_tx_idle, stat_rx_full, host_rovr, rts, irq_tx, irq_rx}, 7'b1100000);
        check("R1 rdata", host_rdata, 0);

        // R2 R3 R7 basic master frame, undivided source, m=2
        cfg_brg = 2; cfg_pre = 0; cfg_tx_en = 1; cfg_rx_en = 1; cts_n = 0;
        peer_sh = 16'h003C;
        pulse_wr(8'hA5);
        @(negedge clk);
        check("R4 irq_tx set", irq_tx, 1);
        wait_done();
        check("R7 rx byte", host_rdata, 8'h3C);
        check("R7 rts high", rts, 1);
        ack_rx = 1; ack_tx = 1; @(negedge clk); ack_rx = 0; ack_tx = 0;
        check("R11 acks", {irq_tx, irq_rx}, 2'b00);
        pulse_rd();
        check("R8 read clears", {stat_rx_full, rts}, 2'b00);

        // R9 back-to-back frames with prescaler, overrun
        cfg_brg = 1; cfg_pre = 2; peer_sh = 16'h5A96;
        pulse_wr(8'h11);
        repeat (3) @(negedge clk);
        pulse_wr(8'h22);
        wait_done();
        check("R9 overrun", host_rovr, 1);
        check("R9 replaced", host_rdata, 8'h5A);
        pulse_rd();
        check("R8 ovr cleared", host_rovr, 0);

        // R5 CTS holds off a start, running frame completes
        cfg_brg = 3; cfg_pre = 1; cts_n = 1; peer_sh = 16'h00F0;
        pulse_wr(8'h77);
        repeat (40) @(negedge clk);
        check("R5 cts hold clk", ser_clk_out, 1);
        check("R5 cts hold buf", stat_tbuf_empty, 0);
        cts_n = 0;
        repeat (12) @(negedge clk);
        cts_n = 1;
        wait_done();
        check("R5 frame completed", host_rdata, 8'hF0);
        check("R6 idle after", stat_tx_idle, 1);
        pulse_rd();
        cts_n = 0;

        // R5 transmit disable holds off a start
        cfg_tx_en = 0; peer_sh = 16'h0081;
        pulse_wr(8'hC3);
        repeat (40) @(negedge clk);
        check("R5 tx_en hold", {ser_clk_out, stat_tbuf_empty}, 2'b10);
        cfg_tx_en = 1;
        wait_done();
        check("R5 enabled frame", host_rdata, 8'h81);
        pulse_rd();

        // R12 receive disabled
        cfg_rx_en = 0; peer_sh = 16'h00E7;
        pulse_wr(8'h5E);
        wait_done();
        check("R12 nothing stored", {stat_rx_full, rts}, 2'b00);
        check("R12 data kept", host_rdata, 8'h81);

        // R10 slave mode
        model_on = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        cfg_ext_clk = 1; cfg_rx_en = 1; cfg_tx_en = 1; ser_clk_in = 1;
        rst_n = 1;
        repeat (4) @(negedge clk);
        ext_frame(8'h6B, cap);
        repeat (6) @(negedge clk);
        check("R10 no dummy no rx", stat_rx_full, 0);
        pulse_wr(8'hA5);
        repeat (3) @(negedge clk);
        check("R4 dummy loaded", stat_tbuf_empty, 1);
        ext_frame(8'hC3, cap);
        repeat (6) @(negedge clk);
        check("R10 slave tx bits", cap, 8'hA5);
        check("R10 slave rx byte", host_rdata, 8'hC3);
        check("R10 slave rx full", {stat_rx_full, rts, irq_rx}, 3'b111);
        check("R3 txd idle after", ser_txd, 1);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule